// File: doc/BRIEF.md
# Effective Address Unit

This sequential unit turns an addressing-mode code, up to two operand bytes and the two 8-bit index registers into a 16-bit effective address. It does this for an 8-bit processor core. Direct modes are resolved from the inputs alone. Pointer modes fetch a two-byte pointer through a read port that accepts one address per cycle. Performing the actual load or store is not part of this unit.

Alongside the address, the unit reports two flags. The first says whether indexing moved the address into another 256-byte page. The second says whether the instruction owes one more bus cycle. A read-class access owes that cycle only when indexing crossed a page. A store-class access in an indexed mode always owes it.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is held and after it is released, done, memRd, effAddr, pageCross and extraCycle are all zero.
- R2: The mode codes are:
  - 0: zero page
  - 1: zero page plus X
  - 2: zero page plus Y
  - 3: absolute
  - 4: absolute plus X
  - 5: absolute plus Y
  - 6: pre-indexed pointer
  - 7: post-indexed pointer
  - 8: jump through pointer
  - 9 to 15: treated as absolute

  For codes other than 6, 7 and 8, done is high for exactly one cycle, in the cycle after start is sampled, and no read is issued.
- R3: The zero-page indexed modes add the index modulo 256 and keep the high byte at zero (0x80 plus X=0xFF gives 0x007F).
- R4: The absolute indexed modes add the index to {opHi,opLo} with a full 16-bit carry (0x0080 plus X=0xFF gives 0x017F; 0xFFFF plus 1 gives 0x0000).
- R5: Pointer modes follow a fixed timing.
  - memRd is high for exactly two consecutive cycles, starting the cycle after start.
  - The first read addresses the pointer's low byte and the second its high byte.
  - Data is returned one cycle after each read.
  - done pulses for one cycle, two cycles after the second read.
- R6: The pre-indexed pointer sits at zero-page address (opLo+X) mod 256. Its high byte comes from the next zero-page address, which wraps from 0xFF to 0x00. The pointer itself is the result.
- R7: The post-indexed pointer sits at zero-page address opLo, with the same in-page wrap for its high byte. The result is the pointer plus Y with a full 16-bit carry.
- R8: The jump through pointer reads its low byte from {opHi,opLo} and its high byte from {opHi,opLo+1}, keeping opHi. A pointer at 0x30FF therefore takes its high byte from 0x3000.
- R9: pageCross is high when the mode is 4, 5 or 7 and the high byte of the unindexed base differs from the high byte of effAddr. It is zero in every other mode.
- R10: extraCycle is high for modes 4, 5 and 7 when isStore is 1, or when isStore is 0 and pageCross is high. It is zero in every other mode.
- R11: While a pointer fetch is in progress, a start pulse is ignored. effAddr, pageCross and extraCycle hold their values from one done pulse to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation; sampled only when idle |
| mode | input | 4 | Addressing mode code (see R2) |
| opLo | input | 8 | First operand byte |
| opHi | input | 8 | Second operand byte |
| idxX | input | 8 | X index register value |
| idxY | input | 8 | Y index register value |
| isStore | input | 1 | 1 for a store-class access, 0 for read-class |
| memRd | output | 1 | Read request for a pointer byte |
| memAddr | output | 16 | Address of the pointer byte requested |
| memData | input | 8 | Byte returned one cycle after a read request |
| effAddr | output | 16 | Resolved effective address |
| done | output | 1 | One-cycle pulse when effAddr is valid |
| pageCross | output | 1 | Indexing moved the address to another page |
| extraCycle | output | 1 | The access needs one more bus cycle |

## Verification
Each mode is driven with operand and index values chosen to sit on the edges that separate one kind of arithmetic from another.
- Zero-page indexing at 0x80 plus 0xFF tells an in-page wrap from a 16-bit carry.
- Absolute indexing at 0x0080 plus 0xFF, and at 0xFFFF plus 1, tells a full carry from a truncated one.
- Pointers at zero-page 0xFF, and a jump pointer at 0x30FF, tell an in-page second-byte fetch from one that steps into the next page.
- Post-indexed and absolute indexed accesses are each run as a read and as a store, with and without a page crossing, which separates the penalty rule for loads from the one for stores.
- A start pulse injected during a pointer fetch shows whether the sequencer can be re-entered.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [3:0] {
    MD_ZP      = 4'd0,
    MD_ZPX     = 4'd1,
    MD_ZPY     = 4'd2,
    MD_ABS     = 4'd3,
    MD_ABSX    = 4'd4,
    MD_ABSY    = 4'd5,
    MD_PREIDX  = 4'd6,
    MD_POSTIDX = 4'd7,
    MD_JMPIND  = 4'd8
  } eauMode_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // latch request inputs (idle and start)
    logic direct;     // resolve a non-pointer mode this cycle
    logic grabLo;     // pointer low byte is on memData; high byte address on memAddr
    logic finishPtr;  // pointer high byte is on memData; resolve now
  } eauStrobe_t;

  function automatic logic usesPointer(input logic [3:0] m);
    return (m == MD_PREIDX) || (m == MD_POSTIDX) || (m == MD_JMPIND);
  endfunction

  function automatic logic carriesIndex(input logic [3:0] m);
    return (m == MD_ABSX) || (m == MD_ABSY) || (m == MD_POSTIDX);
  endfunction

endpackage

// File: rtl/eau_ctrl.sv
module eau_ctrl
  import eau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] mode,
  output eauStrobe_t stb,
  output logic       memRd
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDLO = 2'd1,
    ST_RDHI = 2'd2,
    ST_WAIT = 2'd3
  } ctrlState_e;

  ctrlState_e state, stateNext;
  logic accept;

  assign accept = (state == ST_IDLE) && start;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept && usesPointer(mode)) stateNext = ST_RDLO;
      ST_RDLO: stateNext = ST_RDHI;
      ST_RDHI: stateNext = ST_WAIT;
      ST_WAIT: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb.capture   = accept;
    stb.direct    = accept && !usesPointer(mode);
    stb.grabLo    = (state == ST_RDHI);
    stb.finishPtr = (state == ST_WAIT);
  end

  assign memRd = (state == ST_RDLO) || (state == ST_RDHI);

endmodule

// File: rtl/eau_dp.sv
module eau_dp
  import eau_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  eauStrobe_t        stb,
  input  logic [3:0]        mode,
  input  logic [BYTE_W-1:0] opLo,
  input  logic [BYTE_W-1:0] opHi,
  input  logic [BYTE_W-1:0] idxX,
  input  logic [BYTE_W-1:0] idxY,
  input  logic              isStore,
  input  logic [BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic              done,
  output logic              pageCross,
  output logic              extraCycle
);

  localparam logic [BYTE_W-1:0] PAGE_ZERO = '0;

  // Request state held across a pointer fetch
  logic [3:0]        modeQ;
  logic [BYTE_W-1:0] yQ;
  logic [BYTE_W-1:0] loQ;
  logic              storeQ;
  logic [ADDR_W-1:0] ptrQ;

  // Direct-mode arithmetic
  logic [ADDR_W-1:0] absBase;
  logic [BYTE_W-1:0] zpSumX, zpSumY;
  logic [ADDR_W-1:0] dirBase, dirAddr, ptrInit;

  assign absBase = {opHi, opLo};
  assign zpSumX  = opLo + idxX;  // in-page wrap: carry is dropped
  assign zpSumY  = opLo + idxY;

  always_comb begin
    dirBase = absBase;
    dirAddr = absBase;
    unique case (mode)
      MD_ZP: begin
        dirBase = {PAGE_ZERO, opLo};
        dirAddr = {PAGE_ZERO, opLo};
      end
      MD_ZPX: begin
        dirBase = {PAGE_ZERO, opLo};
        dirAddr = {PAGE_ZERO, zpSumX};
      end
      MD_ZPY: begin
        dirBase = {PAGE_ZERO, opLo};
        dirAddr = {PAGE_ZERO, zpSumY};
      end
      MD_ABSX: dirAddr = absBase + {PAGE_ZERO, idxX};
      MD_ABSY: dirAddr = absBase + {PAGE_ZERO, idxY};
      default: dirAddr = absBase;
    endcase
  end

  always_comb begin
    unique case (mode)
      MD_PREIDX:  ptrInit = {PAGE_ZERO, zpSumX};
      MD_POSTIDX: ptrInit = {PAGE_ZERO, opLo};
      default:    ptrInit = absBase;
    endcase
  end

  // Pointer fetch: the second byte stays in the pointer's page
  logic [BYTE_W-1:0] ptrLoNext;
  assign ptrLoNext = ptrQ[BYTE_W-1:0] + 1'b1;
  assign memAddr   = stb.grabLo ? {ptrQ[ADDR_W-1:BYTE_W], ptrLoNext} : ptrQ;

  logic [ADDR_W-1:0] ptrVal, ptrFinal;
  assign ptrVal   = {memData, loQ};
  assign ptrFinal = (modeQ == MD_POSTIDX) ? ptrVal + {PAGE_ZERO, yQ} : ptrVal;

  // Shared resolution of base, final address and penalty
  logic [ADDR_W-1:0] resBase, resFinal;
  logic              resIndexed, resStore, crossNow, penaltyNow, resolve;

  always_comb begin
    if (stb.direct) begin
      resBase    = dirBase;
      resFinal   = dirAddr;
      resIndexed = carriesIndex(mode);
      resStore   = isStore;
    end else begin
      resBase    = ptrVal;
      resFinal   = ptrFinal;
      resIndexed = carriesIndex(modeQ);
      resStore   = storeQ;
    end
    crossNow   = resIndexed && (resBase[ADDR_W-1:BYTE_W] != resFinal[ADDR_W-1:BYTE_W]);
    penaltyNow = resIndexed && (resStore || crossNow);
  end

  assign resolve = stb.direct || stb.finishPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= '0;
      yQ         <= '0;
      loQ        <= '0;
      storeQ     <= 1'b0;
      ptrQ       <= '0;
      effAddr    <= '0;
      done       <= 1'b0;
      pageCross  <= 1'b0;
      extraCycle <= 1'b0;
    end else begin
      if (stb.capture) begin
        modeQ  <= mode;
        yQ     <= idxY;
        storeQ <= isStore;
        ptrQ   <= ptrInit;
      end
      if (stb.grabLo) loQ <= memData;
      done <= resolve;
      if (resolve) begin
        effAddr    <= resFinal;
        pageCross  <= crossNow;
        extraCycle <= penaltyNow;
      end
    end
  end

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [3:0]            mode,
  input  logic [BYTE_W-1:0]     opLo,
  input  logic [BYTE_W-1:0]     opHi,
  input  logic [BYTE_W-1:0]     idxX,
  input  logic [BYTE_W-1:0]     idxY,
  input  logic                  isStore,
  output logic                  memRd,
  output logic [2*BYTE_W-1:0]   memAddr,
  input  logic [BYTE_W-1:0]     memData,
  output logic [2*BYTE_W-1:0]   effAddr,
  output logic                  done,
  output logic                  pageCross,
  output logic                  extraCycle
);

  eauStrobe_t stb;

  eau_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .mode  (mode),
    .stb   (stb),
    .memRd (memRd)
  );

  eau_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .mode       (mode),
    .opLo       (opLo),
    .opHi       (opHi),
    .idxX       (idxX),
    .idxY       (idxY),
    .isStore    (isStore),
    .memData    (memData),
    .memAddr    (memAddr),
    .effAddr    (effAddr),
    .done       (done),
    .pageCross  (pageCross),
    .extraCycle (extraCycle)
  );

endmodule

// File: rtl/eau_checker.sv
module eau_checker #(
  parameter  int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] effAddr,
  input logic              done,
  input logic              pageCross,
  input logic              extraCycle
);

  // R2: done is a single-cycle pulse
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: a pointer fetch issues two back-to-back reads, then stops
  p_rd_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRd) |=> memRd);

  p_rd_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |=> !memRd);

  // R5: done follows two cycles after the second read
  p_done_after_rd_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |=> !done ##1 done);

  // R8: the second pointer byte stays in the same page
  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |->
      (memAddr[ADDR_W-1:BYTE_W] == $past(memAddr[ADDR_W-1:BYTE_W])) &&
      (memAddr[BYTE_W-1:0] == BYTE_W'($past(memAddr[BYTE_W-1:0]) + 1'b1)));

  // R10: a page crossing always costs the extra cycle
  p_cross_penalty_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && pageCross) |-> extraCycle);

  // R11: results hold between done pulses
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(effAddr) && $stable(pageCross) && $stable(extraCycle)));

endmodule

bind eff_addr_unit eau_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .memRd      (memRd),
  .memAddr    (memAddr),
  .effAddr    (effAddr),
  .done       (done),
  .pageCross  (pageCross),
  .extraCycle (extraCycle)
);

// File: tb/eff_addr_unit_test.sv
module eff_addr_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opLo = '0, opHi = '0, idxX = '0, idxY = '0;
  logic        isStore = 1'b0;
  logic        memRd;
  logic [15:0] memAddr;
  logic [7:0]  memData = '0;
  logic [15:0] effAddr;
  logic        done, pageCross, extraCycle;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  eff_addr_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .opLo(opLo), .opHi(opHi), .idxX(idxX), .idxY(idxY), .isStore(isStore),
    .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .effAddr(effAddr), .done(done), .pageCross(pageCross), .extraCycle(extraCycle)
  );

  // Behavioural memory contents
  function automatic logic [7:0] memFn(input logic [15:0] a);
    case (a)
      16'h30FF: return 8'h80;
      16'h3000: return 8'h40;
      16'h3100: return 8'h50;
      default:  return ((a[7:0] * 8'd7) ^ a[15:8]) + 8'h13;
    endcase
  endfunction

  // Read port: data one cycle after the request
  always @(posedge clk) if (memRd) memData <= memFn(memAddr);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one request and compare every cycle against the model
  task automatic runOp(input string req, input int m, input int lo, input int hi,
                       input int x, input int y, input bit st, input bit poke);
    int base, fin, pA, pB, ptrv;
    bit ptr, idx, pc, ex;
    ptr = (m == 6) || (m == 7) || (m == 8);
    idx = (m == 4) || (m == 5) || (m == 7);
    pA = 0; pB = 0; ptrv = 0;
    case (m)
      0: begin base = lo; fin = lo; end
      1: begin base = lo; fin = (lo + x) % 256; end
      2: begin base = lo; fin = (lo + y) % 256; end
      4: begin base = hi * 256 + lo; fin = (base + x) % 65536; end
      5: begin base = hi * 256 + lo; fin = (base + y) % 65536; end
      6: begin
        pA = (lo + x) % 256; pB = (pA + 1) % 256;
        ptrv = memFn(16'(pA)) + 256 * memFn(16'(pB));
        base = ptrv; fin = ptrv;
      end
      7: begin
        pA = lo; pB = (lo + 1) % 256;
        ptrv = memFn(16'(pA)) + 256 * memFn(16'(pB));
        base = ptrv; fin = (ptrv + y) % 65536;
      end
      8: begin
        pA = hi * 256 + lo; pB = hi * 256 + ((lo + 1) % 256);
        ptrv = memFn(16'(pA)) + 256 * memFn(16'(pB));
        base = ptrv; fin = ptrv;
      end
      default: begin base = hi * 256 + lo; fin = base; end
    endcase
    pc = idx && ((base / 256) != (fin / 256));
    ex = idx && (st || pc);

    @(negedge clk);
    mode = 4'(m); opLo = 8'(lo); opHi = 8'(hi); idxX = 8'(x); idxY = 8'(y);
    isStore = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!ptr) begin
      chk(req, "memRd direct", memRd, 0);
      chk(req, "done", done, 1);
    end else begin
      if (poke) begin start = 1'b1; mode = 4'd0; opLo = 8'h11; end
      chk("R5", "memRd lo", memRd, 1);
      chk(req, "addr lo", memAddr, pA);
      chk("R5", "done early", done, 0);
      @(negedge clk);
      start = 1'b0;
      chk("R5", "memRd hi", memRd, 1);
      chk(req, "addr hi", memAddr, pB);
      chk(poke ? "R11" : "R5", "done early", done, 0);
      @(negedge clk);
      chk("R5", "memRd end", memRd, 0);
      chk("R5", "done early", done, 0);
      @(negedge clk);
      chk("R5", "done", done, 1);
    end
    chk(req, "effAddr", effAddr, fin);
    chk("R9", "pageCross", pageCross, pc);
    chk("R10", "extraCycle", extraCycle, ex);
    @(negedge clk);
    chk("R2", "done pulse", done, 0);
    chk("R11", "effAddr hold", effAddr, fin);
    chk("R5", "memRd idle", memRd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "done", done, 0);
    chk("R1", "memRd", memRd, 0);
    chk("R1", "effAddr", effAddr, 0);
    chk("R1", "pageCross", pageCross, 0);
    chk("R1", "extraCycle", extraCycle, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "done after release", done, 0);

    runOp("R2", 0, 'h44, 'h00, 0, 0, 0, 0);           // zero page
    runOp("R3", 1, 'h80, 'h00, 'hFF, 0, 0, 0);        // wraps to 0x007F
    runOp("R3", 2, 'hF0, 'h00, 0, 'h20, 1, 0);        // store, no penalty
    runOp("R2", 3, 'h00, 'h44, 0, 0, 0, 0);           // absolute
    runOp("R4", 4, 'h80, 'h00, 'hFF, 0, 0, 0);        // 0x017F, crossing
    runOp("R4", 5, 'h10, 'h20, 0, 'h05, 0, 0);        // read, no crossing
    runOp("R10", 5, 'h10, 'h20, 0, 'h05, 1, 0);       // store, no crossing
    runOp("R4", 4, 'hFF, 'hFF, 'h01, 0, 0, 0);        // wraps to 0x0000
    runOp("R2", 15, 'h34, 'h12, 'h01, 'h01, 0, 0);    // unused code
    runOp("R6", 6, 'h20, 'h00, 'h05, 0, 0, 0);
    runOp("R6", 6, 'h80, 'h00, 'h7F, 0, 0, 0);        // pointer at 0xFF
    runOp("R7", 7, 'h40, 'h00, 0, 'h10, 0, 0);        // read, no crossing
    runOp("R7", 7, 'h40, 'h00, 0, 'h10, 1, 0);        // store
    runOp("R7", 7, 'hFF, 'h00, 0, 'hFF, 0, 0);        // wrap and crossing
    runOp("R8", 8, 'hFF, 'h30, 0, 0, 0, 0);           // 0x30FF gives 0x4080
    chk("R8", "jump target", effAddr, 'h4080);
    runOp("R8", 8, 'h34, 'h12, 0, 0, 0, 0);
    runOp("R11", 7, 'h40, 'h00, 0, 'h22, 0, 1);       // start during fetch

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule